// File: doc/BRIEF.md
# Dual Preset Overflow Timer Unit

This unit provides two 8-bit up-counting interval timers for a host that programs it through a byte-wide register write port. A prescaler divides the system clock into a base step of 80 us. The fast timer advances on every base step, and the slow timer advances on every fourth base step, which gives 320 us. Each timer starts from a programmable preset and counts up. When it passes 0xFF it reloads that preset, and it can raise a sticky flag in a status byte that the host reads at any time.

One control register does three jobs. It starts and stops both timers, it enables flag raising for each timer, and it issues a single command that clears both flags. The host picks an interval of N steps by writing 256 minus N as the preset, so a preset of 0 gives the longest interval of 256 steps. The host then polls the status byte and clears it after each event it observes.

Top module: `dual_ovf_timer`

## Requirements
- R1: The fast timer advances once every TICK_CYCLES system clocks (the base step). The slow timer advances once every 4 base steps, so its interval is exactly 4 times longer for the same preset.
- R2: A byte written to index 0x02 is the fast timer preset, and a byte written to index 0x03 is the slow timer preset. A running timer with preset P raises an overflow every 256-P steps, and P=0 gives 256 steps.
- R3: A write to index 0x04 with bit 7 clear loads the control fields: bit 0 runs the fast timer, bit 1 runs the slow timer, bit 6 enables the fast flag, and bit 5 enables the slow flag. A timer that is stopped produces no overflow, and an overflow with its enable bit clear does not set its flag. Writing 0x00 stops both timers.
- R4: A write to index 0x04 with bit 7 set clears both flags and leaves the run and enable bits unchanged.
- R5: When a write turns a run bit from 0 to 1, that counter loads its preset in the same cycle. Its first overflow therefore follows after (N-1)*S+1 to N*S clocks, where S is that timer's step period in clocks.
- R6: A flag, once set, stays set through any number of later overflows until a clear command is written.
- R7: The status byte reads bit 6 = fast flag, bit 5 = slow flag, bit 7 = OR of both flags, and bits 4..0 = 0.
- R8: If an overflow with its flag enabled falls in the same cycle as a clear command, that flag ends up set.
- R9: After reset the status byte reads 0x00 and both timers are stopped.
- R10: Writes to indexes other than 0x02, 0x03 and 0x04 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| wr_idx | input | 8 | Register index of the write |
| wr_data | input | 8 | Data byte of the write |
| rd_stat | output | 8 | Status byte |

## Verification
The clear command and a flag-setting overflow can land on the same clock edge. The bench provokes this by first measuring the overflow instants from the status output. It then places a clear write exactly on the next computed overflow edge, and once more one cycle before a later one. In the first case the status byte must still show the flag right after the edge. In the second case it must read zero for one cycle and then show the flag again.

// File: rtl/dot_pkg.sv
package dot_pkg;
  localparam int NUM_TMR  = 2;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 8;
  localparam int SLOW_DIV = 4;

  localparam logic [IDX_W-1:0] IDX_PRESET0 = 8'h02;
  localparam logic [IDX_W-1:0] IDX_CTRL    = 8'h04;

  localparam int CLR_BIT      = 7;
  localparam int RUN_BIT0     = 0;
  localparam int FLAG_BIT_TOP = 6;

  typedef struct packed {
    logic [NUM_TMR-1:0] run;
    logic [NUM_TMR-1:0] flag_en;
  } ctrl_t;
endpackage

// File: rtl/dot_prescale.sv
module dot_prescale #(
  parameter int TICK_CYCLES = 4000,
  parameter int SLOW_DIV    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [1:0] step
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [PW-1:0] base_q, base_d;
  logic [SW-1:0] slow_q, slow_d;
  logic          base_tick;

  assign base_tick = (base_q == PW'(TICK_CYCLES - 1));

  always_comb begin
    base_d = base_tick ? '0 : base_q + 1'b1;
    slow_d = slow_q;
    if (base_tick) begin
      slow_d = (slow_q == SW'(SLOW_DIV - 1)) ? '0 : slow_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      slow_q <= '0;
    end else begin
      base_q <= base_d;
      slow_q <= slow_d;
    end
  end

  assign step[0] = base_tick;
  assign step[1] = base_tick && (slow_q == SW'(SLOW_DIV - 1));
endmodule

// File: rtl/dot_ctrl.sv
module dot_ctrl
  import dot_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [BYTE_W-1:0]               wr_data,
  output logic [NUM_TMR-1:0][BYTE_W-1:0]  preset,
  output ctrl_t                           ctrl,
  output logic [NUM_TMR-1:0]              start,
  output logic                            clr
);
  ctrl_t ctrl_d;
  logic  ctrl_wr;

  assign ctrl_wr = wr_en && (wr_idx == IDX_CTRL);
  assign clr     = ctrl_wr && wr_data[CLR_BIT];

  always_comb begin
    ctrl_d = ctrl;
    if (ctrl_wr && !wr_data[CLR_BIT]) begin
      for (int i = 0; i < NUM_TMR; i++) begin
        ctrl_d.run[i]     = wr_data[RUN_BIT0 + i];
        ctrl_d.flag_en[i] = wr_data[FLAG_BIT_TOP - i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_d;
  end

  assign start = ctrl_d.run & ~ctrl.run;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_preset
    logic pre_wr;
    assign pre_wr = wr_en && (wr_idx == IDX_PRESET0 + IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      preset[g] <= '0;
      else if (pre_wr) preset[g] <= wr_data;
    end
  end
endmodule

// File: rtl/dot_counter.sv
module dot_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] preset,
  output logic         ovf
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = start || (run && step);

  always_comb begin
    cnt_d = cnt_q;
    ovf   = 1'b0;
    if (start) begin
      cnt_d = preset;
    end else if (run && step) begin
      if (cnt_q == '1) begin
        cnt_d = preset;
        ovf   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dual_ovf_timer.sv
module dual_ovf_timer
  import dot_pkg::*;
#(
  parameter int TICK_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_stat
);
  logic [1:0]                      rst_ff;
  logic                            rst_sync_n;
  logic [1:0]                      step;
  logic [NUM_TMR-1:0][BYTE_W-1:0]  preset;
  ctrl_t                           ctrl;
  logic [NUM_TMR-1:0]              start;
  logic                            clr;
  logic [NUM_TMR-1:0]              ovf;
  logic [NUM_TMR-1:0]              flag_q, flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  dot_prescale #(.TICK_CYCLES(TICK_CYCLES), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .step (step)
  );

  dot_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .preset (preset),
    .ctrl   (ctrl),
    .start  (start),
    .clr    (clr)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    dot_counter #(.W(BYTE_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .start (start[g]),
      .run   (ctrl.run[g]),
      .step  (step[g]),
      .preset(preset[g]),
      .ovf   (ovf[g])
    );

    always_comb begin
      flag_d[g] = flag_q[g];
      if (clr)                          flag_d[g] = 1'b0;
      if (ovf[g] && ctrl.flag_en[g])    flag_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) flag_q[g] <= 1'b0;
      else             flag_q[g] <= flag_d[g];
    end
  end

  assign rd_stat = {|flag_q, flag_q[0], flag_q[1], 5'b0};
endmodule

// File: rtl/dot_checker.sv
module dot_checker
  import dot_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                clr,
  input logic [NUM_TMR-1:0]  start,
  input logic [NUM_TMR-1:0]  ovf,
  input logic [NUM_TMR-1:0]  run,
  input logic [NUM_TMR-1:0]  flag_en,
  input logic [NUM_TMR-1:0]  flag,
  input logic [BYTE_W-1:0]   stat
);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(|ovf)) |=> (stat == 8'h00));

  p_summary_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[7]) |-> ($rose(stat[6]) || $rose(stat[5])));

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[g] && flag_en[g]) |=> flag[g]);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[g] && !clr) |=> flag[g]);

    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[g] && !(ovf[g] && flag_en[g])) |=> !flag[g]);

    p_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run[g] |-> !ovf[g]);

    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start[g] |=> run[g]);
  end
endmodule

bind dual_ovf_timer dot_checker u_dot_checker (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .clr    (clr),
  .start  (start),
  .ovf    (ovf),
  .run    (ctrl.run),
  .flag_en(ctrl.flag_en),
  .flag   (flag_q),
  .stat   (rd_stat)
);

// File: tb/test_dual_ovf_timer.sv
module test_dual_ovf_timer;
  localparam int T = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_stat;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_ovf_timer #(.TICK_CYCLES(T)) i_dual_ovf_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_stat(rd_stat)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] dat);
    wr_idx = idx; wr_data = dat; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_flag(input logic [7:0] mask, input int limit, output int at);
    at = -1;
    for (int k = 0; k <= limit; k++) begin
      if ((rd_stat & mask) != 0) begin
        at = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic measure(input int t, input int n);
    int s, r1, r2, step;
    logic [7:0] mask;
    step = (t == 0) ? T : 4 * T;
    mask = (t == 0) ? 8'h40 : 8'h20;
    wr(8'h04, 8'h00);
    wr(8'h04, 8'h80);
    wr(8'h02 + 8'(t), 8'(256 - n));
    wr(8'h04, (t == 0) ? 8'h41 : 8'h22);
    s = cyc;
    wait_flag(mask, n * step + 2, r1);
    check_range("R5 first overflow delay", r1 - s, (n - 1) * step + 1, n * step);
    check("R7 status with one flag", rd_stat, 8'h80 | mask);
    wr(8'h04, 8'h80);
    check("R4 clear", rd_stat, 0);
    wait_flag(mask, n * step + 2, r2);
    check("R1 R2 overflow interval", r2 - r1, n * step);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int r, c;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R9: quiet after reset, nothing running
    check("R9 reset status", rd_stat, 0);
    idle(60);
    check("R9 stays stopped", rd_stat, 0);

    // R1 R2 R5 R7 R4: fast timer sweep, N = 1,18,...,256 (preset 0 for 256)
    for (int n = 1; n <= 256; n += 17) measure(0, n);
    // slow timer
    measure(1, 1);
    measure(1, 2);
    measure(1, 7);
    measure(1, 64);
    measure(1, 256);

    // R3: run without flag enable raises nothing
    wr(8'h04, 8'h00);
    wr(8'h04, 8'h80);
    wr(8'h02, 8'd252);
    wr(8'h04, 8'h01);
    idle(60);
    check("R3 disabled flag", rd_stat, 0);
    wr(8'h04, 8'h41);
    wait_flag(8'h40, 4 * T + 2, r);
    check("R3 enable while running", (r >= 0) ? 1 : 0, 1);

    // R3: stop with 0x00, enable alone does not run
    wr(8'h04, 8'h00);
    wr(8'h04, 8'h80);
    idle(100);
    check("R3 stopped", rd_stat, 0);
    wr(8'h04, 8'h40);
    idle(100);
    check("R3 enable without run", rd_stat, 0);

    // R6 R7: both flags, sticky through many overflows
    wr(8'h02, 8'hFF);
    wr(8'h03, 8'hFF);
    wr(8'h04, 8'h63);
    idle(20);
    check("R7 both flags", rd_stat, 8'hE0);
    idle(60);
    check("R6 sticky", rd_stat, 8'hE0);
    check("R7 unused bits", rd_stat & 8'h1F, 0);
    wr(8'h04, 8'h00);
    wr(8'h04, 8'h80);
    check("R4 clear both", rd_stat, 0);

    // R10: other indexes have no effect
    wr(8'h05, 8'h41);
    wr(8'h01, 8'h63);
    wr(8'h00, 8'h22);
    wr(8'h84, 8'h41);
    idle(100);
    check("R10 foreign index", rd_stat, 0);

    // R8: clear on the very overflow edge; N=10, interval 30 clocks
    wr(8'h02, 8'd246);
    wr(8'h04, 8'h41);
    wait_flag(8'h40, 40, r);
    wr(8'h04, 8'h80);
    c = r + 10 * T;
    wait_until(c - 1);
    check("R8 cleared before edge", rd_stat, 0);
    wr(8'h04, 8'h80);
    check("R8 set wins over clear", rd_stat, 8'hC0);
    c = c + 10 * T;
    wait_until(c - 2);
    wr(8'h04, 8'h80);
    check("R8 clear one cycle early", rd_stat, 0);
    @(negedge clk);
    check("R8 next overflow sets", rd_stat, 8'hC0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule